// File: doc/BRIEF.md
# Landing Door Controller

This block governs one elevator landing door. It runs a four-state machine (closed, opening, waiting, closing) that drives a motor-enable line and a direction line. It watches two end-of-travel switches and a light barrier across the doorway. A higher-level controller asks for the door to open with a one-cycle request. The block tells the cage controller, with a one-cycle pulse, that the door has reached full closure. An emergency shutdown input overrides everything and parks the door, with the motor stopped.

The machine comes out of reset in the closing state, so a door left ajar at power-up is driven shut. When the door reaches the open switch it stops and holds for a programmable time of `CLK_HZ * HOLD_SEC` clock cycles (10 seconds by default), and then closes again. If something blocks the light barrier while the door is closing, the door reverses and reopens. All inputs are assumed to be synchronous to `clk` and already debounced.

Named states: `ST_CLOSED`, `ST_OPENING`, `ST_WAITING`, `ST_CLOSING`. Named transitions: *reset-shut* (reset to closing), *request* (closed or closing to opening), *reach-open* (opening to waiting, which loads the hold timer), *hold-restart* (waiting to waiting on a request, which reloads the timer), *expire* (waiting to closing), *reach-shut* (closing to closed, which sends the start pulse), *reverse* (closing to opening on the barrier), and *halt* (any state to closed on shutdown).

Top module: `door_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs show the closing state: `motor_on_o`=1, `dir_open_o`=0, `start_o`=0.
- R2: The outputs encode the state as (`motor_on_o`,`dir_open_o`): closed=(0,0), opening=(1,1), waiting=(0,1), closing=(1,0). `dir_open_o`=1 means the open direction.
- R3: When `halt_i`=1 at a clock edge, the next cycle shows closed (0,0), whatever the other inputs are. The machine stays closed for as long as `halt_i` stays high, and it produces no start pulse.
- R4: An `open_req_i` pulse in closed or closing gives opening (1,1) in the next cycle.
- R5: In opening, `lim_open_i`=1 gives waiting (0,1) in the next cycle. In every other state `lim_open_i` has no effect.
- R6: The machine shows waiting for exactly `CLK_HZ*HOLD_SEC` consecutive cycles and then shows closing (1,0).
- R7: In closing, with `lim_shut_i`=1, `beam_cut_i`=0 and no request, the next cycle shows closed (0,0), and `start_o`=1 in that same cycle.
- R8: In closing, `beam_cut_i`=1 gives opening (1,1) in the next cycle, even when `lim_shut_i` is also high. A request in the same cycle as `lim_shut_i` also takes the door back to opening.
- R9: An `open_req_i` in waiting restarts the full hold, counted from the cycle after the request, with the outputs staying at (0,1) throughout. This also holds in the cycle in which the hold would have expired. A request in opening leaves the outputs at (1,1).
- R10: `start_o` is high for exactly one cycle per closure, and never in any other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Emergency shutdown, highest priority |
| open_req_i | input | 1 | One-cycle open request from the supervisor |
| lim_open_i | input | 1 | Door fully open switch |
| lim_shut_i | input | 1 | Door fully shut switch |
| beam_cut_i | input | 1 | Light barrier interrupted (1) |
| motor_on_o | output | 1 | Motor enable |
| dir_open_o | output | 1 | Motor direction: 1 open, 0 close |
| start_o | output | 1 | One-cycle pulse on full closure |

## Verification
The bench goes after the hold length by placing a restart request at every offset of a small hold window, including the cycle in which the hold expires. A timer that is off by one, or that lets the expiry beat the reload, would close the door a cycle early or ignore the restart. It sets a blocked barrier against the shut switch in the same cycle: a design that ranks the switch first would report a closure while someone is standing in the doorway. It applies shutdown while the door is closing on the shut switch and while a request is pending. A wrong priority would let the motor run, or would send a start pulse for a closure that never happened. It also drives the end-of-travel switches in states where they do not apply and checks that they leave the outputs unchanged.

// File: rtl/door_pkg.sv
package door_pkg;

    // State codes; the output decode in door_fsm depends on these four values.
    typedef enum logic [1:0] {
        ST_CLOSED  = 2'd0,
        ST_OPENING = 2'd1,
        ST_WAITING = 2'd2,
        ST_CLOSING = 2'd3
    } door_state_e;

    // Width needed for a down-counter starting at ticks-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned ticks);
        return (ticks > 1) ? $clog2(ticks) : 1;
    endfunction

endpackage

// File: rtl/door_hold_timer.sv
module door_hold_timer #(
    parameter int unsigned HOLD_TICKS = 10,
    parameter int unsigned CNT_W      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,     // start (or restart) a full hold
    input  logic run_i,      // machine is in the waiting state
    output logic expired_o   // final cycle of the hold
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_TICKS - 1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= RELOAD;
        end else if (run_i && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired_o = run_i && (remain_q == '0);

endmodule

// File: rtl/door_fsm.sv
module door_fsm
    import door_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic open_req_i,
    input  logic lim_open_i,
    input  logic lim_shut_i,
    input  logic beam_cut_i,
    input  logic hold_done_i,
    output logic hold_load_o,
    output logic hold_run_o,
    output logic motor_on_o,
    output logic dir_open_o,
    output logic start_o
);

    door_state_e state_q, state_d;
    logic        shut_evt;
    logic        start_q;

    // State register: reset lands in closing so the door is driven shut.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLOSING;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= shut_evt;
        end
    end

    // Next-state logic with priority: halt, then per-state guards.
    always_comb begin
        state_d     = state_q;
        shut_evt    = 1'b0;
        hold_load_o = 1'b0;
        if (halt_i) begin
            state_d = ST_CLOSED;                       // halt
        end else begin
            unique case (state_q)
                ST_CLOSED: begin
                    if (open_req_i) state_d = ST_OPENING;   // request
                end
                ST_OPENING: begin
                    if (lim_open_i) begin                   // reach-open
                        state_d     = ST_WAITING;
                        hold_load_o = 1'b1;
                    end
                end
                ST_WAITING: begin
                    if (open_req_i) begin                   // hold-restart
                        hold_load_o = 1'b1;
                    end else if (hold_done_i) begin         // expire
                        state_d = ST_CLOSING;
                    end
                end
                ST_CLOSING: begin
                    if (beam_cut_i) begin                   // reverse
                        state_d = ST_OPENING;
                    end else if (open_req_i) begin          // request
                        state_d = ST_OPENING;
                    end else if (lim_shut_i) begin          // reach-shut
                        state_d  = ST_CLOSED;
                        shut_evt = 1'b1;
                    end
                end
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        motor_on_o = 1'b0;
        dir_open_o = 1'b0;
        unique case (state_q)
            ST_CLOSED:  begin motor_on_o = 1'b0; dir_open_o = 1'b0; end
            ST_OPENING: begin motor_on_o = 1'b1; dir_open_o = 1'b1; end
            ST_WAITING: begin motor_on_o = 1'b0; dir_open_o = 1'b1; end
            ST_CLOSING: begin motor_on_o = 1'b1; dir_open_o = 1'b0; end
        endcase
    end

    assign hold_run_o = (state_q == ST_WAITING);
    assign start_o    = start_q;

endmodule

// File: rtl/door_ctrl.sv
module door_ctrl
    import door_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned HOLD_SEC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic open_req_i,
    input  logic lim_open_i,
    input  logic lim_shut_i,
    input  logic beam_cut_i,
    output logic motor_on_o,
    output logic dir_open_o,
    output logic start_o
);

    localparam int unsigned HOLD_TICKS = CLK_HZ * HOLD_SEC;
    localparam int unsigned CNT_W      = cnt_width(HOLD_TICKS);

    logic hold_load;
    logic hold_run;
    logic hold_done;

    door_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_i      (halt_i),
        .open_req_i  (open_req_i),
        .lim_open_i  (lim_open_i),
        .lim_shut_i  (lim_shut_i),
        .beam_cut_i  (beam_cut_i),
        .hold_done_i (hold_done),
        .hold_load_o (hold_load),
        .hold_run_o  (hold_run),
        .motor_on_o  (motor_on_o),
        .dir_open_o  (dir_open_o),
        .start_o     (start_o)
    );

    door_hold_timer #(
        .HOLD_TICKS (HOLD_TICKS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (hold_load),
        .run_i     (hold_run),
        .expired_o (hold_done)
    );

endmodule

// File: rtl/door_ctrl_chk.sv
module door_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_i,
    input logic open_req_i,
    input logic lim_open_i,
    input logic lim_shut_i,
    input logic beam_cut_i,
    input logic motor_on_o,
    input logic dir_open_o,
    input logic start_o
);

    AST_HALT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (!motor_on_o && !dir_open_o && !start_o)); // R3

    AST_REACH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_on_o && dir_open_o && lim_open_i && !halt_i) |=> (!motor_on_o && dir_open_o)); // R5

    AST_BEAM_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_on_o && !dir_open_o && beam_cut_i && !halt_i) |=> (motor_on_o && dir_open_o)); // R8

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(motor_on_o && !dir_open_o && lim_shut_i && !beam_cut_i && !open_req_i && !halt_i)); // R7

    AST_START_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!motor_on_o && !dir_open_o)); // R7

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R10

    AST_WAIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!motor_on_o && dir_open_o && open_req_i && !halt_i) |=> (!motor_on_o && dir_open_o)); // R9

endmodule

bind door_ctrl door_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_i     (halt_i),
    .open_req_i (open_req_i),
    .lim_open_i (lim_open_i),
    .lim_shut_i (lim_shut_i),
    .beam_cut_i (beam_cut_i),
    .motor_on_o (motor_on_o),
    .dir_open_o (dir_open_o),
    .start_o    (start_o)
);

// File: tb/door_ctrl_tb.sv
`timescale 1ns/1ps
module door_ctrl_tb;

    localparam int TB_HZ  = 3;
    localparam int TB_SEC = 2;
    localparam int HOLD   = TB_HZ * TB_SEC;   // expected waiting length in cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_i = 1'b0, open_req_i = 1'b0, lim_open_i = 1'b0;
    logic lim_shut_i = 1'b0, beam_cut_i = 1'b0;
    logic motor_on_o, dir_open_o, start_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    door_ctrl #(.CLK_HZ(TB_HZ), .HOLD_SEC(TB_SEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .open_req_i(open_req_i),
        .lim_open_i(lim_open_i), .lim_shut_i(lim_shut_i), .beam_cut_i(beam_cut_i),
        .motor_on_o(motor_on_o), .dir_open_o(dir_open_o), .start_o(start_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_out(input logic em, input logic ed, input logic es, input string req);
        checks++;
        if (motor_on_o !== em || dir_open_o !== ed || start_o !== es) begin
            errors++;
            $display("FAIL %s: got motor=%0b dir=%0b start=%0b, expected motor=%0b dir=%0b start=%0b",
                     req, motor_on_o, dir_open_o, start_o, em, ed, es);
        end
    endtask

    task automatic pulse_req();
        open_req_i = 1'b1; tick(); open_req_i = 1'b0;
    endtask

    task automatic pulse_open_lim();
        lim_open_i = 1'b1; tick(); lim_open_i = 1'b0;
    endtask

    // Already in the first waiting cycle: expect HOLD waiting cycles, then closing.
    task automatic run_hold(input string req);
        for (int i = 1; i < HOLD; i++) begin
            tick(); expect_out(1'b0, 1'b1, 1'b0, req);
        end
        tick(); expect_out(1'b1, 1'b0, 1'b0, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        expect_out(1'b1, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        tick(); expect_out(1'b1, 1'b0, 1'b0, "R1 after release");

        // R5: open switch ignored while closing
        lim_open_i = 1'b1; tick(); lim_open_i = 1'b0;
        expect_out(1'b1, 1'b0, 1'b0, "R5 open switch ignored in closing");

        // R7: closure with start pulse
        lim_shut_i = 1'b1; tick(); lim_shut_i = 1'b0;
        expect_out(1'b0, 1'b0, 1'b1, "R7 closure pulse");
        tick(); expect_out(1'b0, 1'b0, 1'b0, "R10 pulse one cycle");

        // R5 / R2: switches ignored in closed
        lim_open_i = 1'b1; lim_shut_i = 1'b1; tick(); lim_open_i = 1'b0; lim_shut_i = 1'b0;
        expect_out(1'b0, 1'b0, 1'b0, "R5 switches ignored in closed");

        pulse_req();      expect_out(1'b1, 1'b1, 1'b0, "R4 request from closed");
        pulse_req();      expect_out(1'b1, 1'b1, 1'b0, "R9 request in opening");
        pulse_open_lim(); expect_out(1'b0, 1'b1, 1'b0, "R5 reach open");
        run_hold("R6 hold length");

        // R8: barrier beats shut switch
        beam_cut_i = 1'b1; lim_shut_i = 1'b1; tick(); beam_cut_i = 1'b0; lim_shut_i = 1'b0;
        expect_out(1'b1, 1'b1, 1'b0, "R8 barrier over shut switch");
        pulse_open_lim(); expect_out(1'b0, 1'b1, 1'b0, "R5 reach open again");

        // R9: restart at every offset of the hold, including the expiry cycle
        for (int k = 0; k < HOLD; k++) begin
            for (int j = 0; j < k; j++) begin
                tick(); expect_out(1'b0, 1'b1, 1'b0, "R9 before restart");
            end
            pulse_req(); expect_out(1'b0, 1'b1, 1'b0, "R9 restart keeps waiting");
            run_hold("R9 full hold after restart");
            if (k % 2 == 0) begin
                open_req_i = 1'b1; lim_shut_i = 1'b1; tick(); open_req_i = 1'b0; lim_shut_i = 1'b0;
                expect_out(1'b1, 1'b1, 1'b0, "R8 request over shut switch");
            end else begin
                pulse_req(); expect_out(1'b1, 1'b1, 1'b0, "R4 request from closing");
            end
            pulse_open_lim(); expect_out(1'b0, 1'b1, 1'b0, "R5 reach open loop");
        end

        // R3: halt while waiting with a request, held for several cycles
        halt_i = 1'b1; open_req_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(); expect_out(1'b0, 1'b0, 1'b0, "R3 halt holds closed");
        end
        halt_i = 1'b0; tick(); open_req_i = 1'b0;
        expect_out(1'b1, 1'b1, 1'b0, "R4 request after halt");
        pulse_open_lim(); expect_out(1'b0, 1'b1, 1'b0, "R5 reach open after halt");
        run_hold("R6 hold after halt");

        // R3 / R10: halt during closing on shut switch gives no pulse
        halt_i = 1'b1; lim_shut_i = 1'b1; tick(); halt_i = 1'b0; lim_shut_i = 1'b0;
        expect_out(1'b0, 1'b0, 1'b0, "R10 no pulse on halt");
        tick(); expect_out(1'b0, 1'b0, 1'b0, "R10 still quiet");

        // R3: halt during opening with open switch
        pulse_req(); expect_out(1'b1, 1'b1, 1'b0, "R4 request before halt");
        halt_i = 1'b1; lim_open_i = 1'b1; tick(); halt_i = 1'b0; lim_open_i = 1'b0;
        expect_out(1'b0, 1'b0, 1'b0, "R3 halt beats open switch");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule